// File: doc/BRIEF.md
# Per-pin programmable GPIO debounce filter

This block cleans up a bank of general-purpose input lines. Every line first passes through a two-flop synchroniser. A per-line filter then lets a new level through to the output only after the synchronised level has stayed the same for a chosen time. Each line picks its own time from seven settings between 1 us and 30 ms. The time is counted in ticks of a free-running prescaler that divides the system clock down to one tick per microsecond.

Software sets the times through 32-bit configuration words. Each word holds eight 4-bit fields, one per line. In each field, bits 2:0 hold a code and bit 3 is a write-enable. A write therefore updates only the fields whose enable bit is set, with no read-modify-write. Banks wider than eight lines use one word per eight lines. Reads return the stored codes. The write and read ports are plain register strobes. There is no streaming data path, so no valid/ready handshake is used.

Top module: `gpio_debounce_bank`

## Requirements
- R1: After reset, every configuration field reads 0 and every bit of pin_filt is 0.
- R2: Line n is configured by the field at bits (n mod 8)*4+3 .. (n mod 8)*4 of word n/8. The code in bits 2:0 selects a steady time of 1, 10, 100, 1000, 10000, 20000 or 30000 ticks for codes 0 to 6 respectively.
- R3: On a write (wr_en high at a rising clock edge), a field of word wr_sel takes wr_data bits 2:0 of that field only when wr_data bit 3 of that field is 1. Fields whose enable bit is 0 keep their value.
- R4: A field in rd_data shows the stored code in bits 2:0 and 0 in bit 3. rd_data is combinational from rd_sel.
- R5: A write changes only the word named by wr_sel. A wr_sel of NUM_REGS or more changes nothing and reads as 0.
- R6: One tick lasts TICK_DIV clock cycles. With TICK_DIV=1, a level applied to pin_raw[n] before rising edge E0 and held appears on pin_filt[n] right after rising edge E0+L+2, where L is the tick count of the line's code.
- R7: Any change of the synchronised level restarts the line's count. A pulse shorter than the selected time never reaches pin_filt, and after a bounce the delay of R6 is measured from the last change.
- R8: Codes 7 and above act like code 0 (1 tick).
- R9: Lines are independent. Each line changes at its own time, set by its own code, and changes on one line do not move another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | SEL_W | Index of the configuration word to write |
| wr_data | input | 32 | Write data: eight fields of {enable, code[2:0]} |
| rd_sel | input | SEL_W | Index of the configuration word to read |
| rd_data | output | 32 | Read-back of the selected word |
| pin_raw | input | NUM_PINS | Unsynchronised input lines |
| pin_filt | output | NUM_PINS | Debounced levels |

## Verification
The hardest case to reach from the ports is a bounce that happens inside a running count. Seen from outside, it has to prove that the count was restarted and not merely paused. The bench sets the prescaler to one tick per cycle. It toggles a line while the line is still counting, then checks that the output moves exactly L+2 edges after the final toggle and at no earlier cycle. The longest setting, 30000 ticks, and the out-of-range code 7 are also driven through the same cycle-exact scoreboard.

// File: rtl/gpio_deb_pkg.sv
package gpio_deb_pkg;
  localparam int CODE_W  = 3;
  localparam int FIELD_W = 4;
  localparam int FIELDS_PER_REG = 8;
  localparam int CNT_W = 15;

  function automatic logic [CNT_W-1:0] ticks_for_code(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    ticks_for_code = CNT_W'(10);
      3'd2:    ticks_for_code = CNT_W'(100);
      3'd3:    ticks_for_code = CNT_W'(1000);
      3'd4:    ticks_for_code = CNT_W'(10000);
      3'd5:    ticks_for_code = CNT_W'(20000);
      3'd6:    ticks_for_code = CNT_W'(30000);
      default: ticks_for_code = CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/deb_tick_gen.sv
module deb_tick_gen #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == DW'(TICK_DIV - 1)) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == DW'(TICK_DIV - 1));

      // R6: ticks are never back to back when dividing
      a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/deb_cfg_regs.sv
module deb_cfg_regs
  import gpio_deb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_REGS = 1,
  parameter int SEL_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [31:0]                wr_data,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [31:0]                rd_data,
  output logic [NUM_PINS*CODE_W-1:0] pin_codes
);
  localparam int NUM_FIELDS = NUM_REGS * FIELDS_PER_REG;

  logic [CODE_W-1:0] code_q [NUM_FIELDS];
  logic [31:0]       word_view [NUM_REGS];

  genvar r, f;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_reg
      for (f = 0; f < FIELDS_PER_REG; f++) begin : g_fld
        localparam int IDX = r * FIELDS_PER_REG + f;
        localparam int LSB = f * FIELD_W;
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(r)) && wr_data[LSB+3];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   code_q[IDX] <= '0;
          else if (hit) code_q[IDX] <= wr_data[LSB +: CODE_W];
        end
        assign word_view[r][LSB +: FIELD_W] = {1'b0, code_q[IDX]};

        // R3: a field without its enable bit set keeps its code
        a_r3_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
          !(wr_en && (wr_sel == SEL_W'(r)) && wr_data[LSB+3]) |=> $stable(code_q[IDX]));
        // R3: an enabled write lands the written code
        a_r3_field_load: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && (wr_sel == SEL_W'(r)) && wr_data[LSB+3])
            |=> code_q[IDX] == $past(wr_data[LSB +: CODE_W]));
      end
    end
    for (r = 0; r < NUM_PINS; r++) begin : g_pin
      assign pin_codes[r*CODE_W +: CODE_W] = code_q[r];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel == SEL_W'(i)) rd_data = word_view[i];
  end
endmodule

// File: rtl/deb_pin_filter.sv
module deb_pin_filter
  import gpio_deb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              raw,
  input  logic [CODE_W-1:0] code,
  output logic              filt
);
  logic meta_q, sync_q, last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = ticks_for_code(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
      filt   <= 1'b0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      last_q <= sync_q;
      if (sync_q != last_q || sync_q == filt) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q + 1'b1 >= limit) begin
          filt  <= sync_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: output only moves after a cycle in which the synchronised level was steady
  a_r7_steady_before_move: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> $past(sync_q) == $past(last_q));
  // R6: output only moves on a prescaler tick
  a_r6_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> $past(tick));
  // R6: output takes the synchronised level
  a_r6_move_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> filt == $past(sync_q));
endmodule

// File: rtl/gpio_debounce_bank.sv
module gpio_debounce_bank
  import gpio_deb_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int TICK_DIV = 100,
  parameter int NUM_REGS = (NUM_PINS + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  parameter int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [31:0]         wr_data,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_filt
);
  logic tick;
  logic [NUM_PINS*CODE_W-1:0] pin_codes;

  deb_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  deb_cfg_regs #(.NUM_PINS(NUM_PINS), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pin_codes(pin_codes)
  );

  genvar n;
  generate
    for (n = 0; n < NUM_PINS; n++) begin : g_filt
      deb_pin_filter u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(pin_raw[n]),
        .code(pin_codes[n*CODE_W +: CODE_W]), .filt(pin_filt[n])
      );
    end
  endgenerate
endmodule

// File: tb/gpio_debounce_bank_bench.sv
module gpio_debounce_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [0:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [0:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_filt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  logic [NP-1:0] seen = '0;

  typedef struct { int pin; bit val; int at; string req; } exp_t;
  exp_t sb[$];

  gpio_debounce_bank #(.NUM_PINS(NP), .TICK_DIV(1)) u_gpio_debounce_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[0:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input int sel, input logic [31:0] exp, input string req);
    rd_sel = sel[0:0];
    #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  // driver: sets a line at a falling edge and, if a change is due, queues it
  task automatic drive(input int pin, input bit v, input int lim, input bit expect_move, input string req);
    @(negedge clk);
    pin_raw[pin] = v;
    if (expect_move) sb.push_back('{pin, v, cyc + lim + 3, req});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every change of pin_filt must match the head of the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < NP; i++) begin
        if (pin_filt[i] !== seen[i]) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected output change on line", i, -1);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.pin == i && e.val == pin_filt[i] && e.at == cyc,
                  e.req, (longint'(i) << 32) | cyc, (longint'(e.pin) << 32) | e.at);
          end
          seen[i] = pin_filt[i];
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(pin_filt == '0, "R1 pin_filt after reset", pin_filt, 0);
    rd_check(0, 32'h0, "R1 word0 after reset");
    rd_check(1, 32'h0, "R1 word1 after reset");
    mon_on = 1'b1;

    // R3/R4: line0 code2, line1 code1, line2 code5 without enable
    wr(0, 32'h0000_059A);
    rd_check(0, 32'h0000_0012, "R3 enabled fields only, R4 bit3 reads 0");
    // R3: no enable bits, nothing moves
    wr(0, 32'h7777_7777);
    rd_check(0, 32'h0000_0012, "R3 write without enables ignored");
    // R2/R5: line8 lives in word1 field0
    wr(1, 32'h0000_000B);
    rd_check(1, 32'h0000_0003, "R5 word1 written");
    rd_check(0, 32'h0000_0012, "R5 word0 untouched by word1 write");

    // R6/R9: line1 (10 ticks) and line0 (100 ticks) raised together
    @(negedge clk);
    pin_raw[0] = 1'b1; pin_raw[1] = 1'b1;
    sb.push_back('{1, 1'b1, cyc + 13, "R9 line1 at its own time"});
    sb.push_back('{0, 1'b1, cyc + 103, "R6 line0 100 ticks"});
    idle(120);
    check(sb.size() == 0, "R9 both lines moved", sb.size(), 0);

    // R7: short pulse on line1 never gets through
    drive(1, 1'b0, 10, 1'b0, "");
    idle(5);
    drive(1, 1'b1, 10, 1'b0, "");
    idle(30);
    check(pin_filt[1] == 1'b1, "R7 short pulse filtered", pin_filt[1], 1);

    // R7: bounce on line0, delay from the last change
    drive(0, 1'b0, 100, 1'b0, "");
    idle(40);
    drive(0, 1'b1, 100, 1'b0, "");
    idle(3);
    drive(0, 1'b0, 100, 1'b1, "R7 restart after bounce");
    idle(120);

    // R2: line8 with code3 (1000 ticks)
    drive(8, 1'b1, 1000, 1'b1, "R2 code3 1000 ticks");
    idle(1010);

    // R8: line2 code7 acts as 1 tick
    wr(0, 32'h0000_0F00);
    rd_check(0, 32'h0000_0712, "R4 code7 read back");
    drive(2, 1'b1, 1, 1'b1, "R8 code7 as 1 tick");
    idle(10);
    // R2: code0 on line4 is 1 tick
    drive(4, 1'b1, 1, 1'b1, "R2 code0 1 tick");
    idle(10);

    // R2: line3 code6 (30000 ticks)
    wr(0, 32'h0000_E000);
    rd_check(0, 32'h0000_6712, "R3 single field write keeps neighbours");
    drive(3, 1'b1, 30000, 1'b1, "R2 code6 30000 ticks");
    idle(30010);

    // R5: line8 falls again, word1 code unaffected by word0 writes
    rd_check(1, 32'h0000_0003, "R5 word1 after word0 writes");
    drive(8, 1'b0, 1000, 1'b1, "R6 falling edge 1000 ticks");
    idle(1010);

    check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule